// File: doc/BRIEF.md
# Branch Resolution and Instruction-Set Switch Unit

This block resolves one branch per accepted request. Given the address of the branch instruction, the instruction-set state the core is currently in, the branch kind and its operand (a signed byte offset for immediate branches or a register value for exchange branches), it produces the address to fetch next and the instruction-set state that applies there. It also decides whether the link register is written and with what value. Separately, it reports the value an instruction sees when it reads the program counter as an operand.

Results are registered. A request presented with `valid_i` high at a rising clock edge appears on the outputs after that edge. While `valid_i` is low, the outputs keep their values and the link write enable is low. Condition evaluation happens outside this block, and only its pass or fail result enters here.

Top module: `bwl_unit`

## Requirements
- R1: `pc_read_o` equals the instruction address plus 8 when the state is wide (`isa_i`=2'b00), and plus 4 in every other state.
- R2: Immediate branches (`kind_i` 2'b00 plain, 2'b01 with link) target `pc_read` plus the sign-extended byte offset and keep the current state.
- R3: Register exchange branches (`kind_i` 2'b10 plain, 2'b11 with link) take their target from `target_i`. Target bit 0 = 1 selects the narrow state 2'b01, and bit 0 = 0 selects the wide state 2'b00.
- R4: The next PC is aligned for the state it enters. Bits [1:0] are cleared for wide (2'b00). Bit 0 is cleared for narrow (2'b01) and extended narrow (2'b11). The bytecode state (2'b10) is left unaligned.
- R5: `link_we_o` is high only for linking kinds (2'b01, 2'b11) whose condition passed. `link_val_o` is the address of the following instruction. The instruction size is 4 in wide state, and otherwise 4 if `ins32_i` is high and 2 if it is low.
- R6: When the caller is in narrow or extended narrow state, bit 0 of the link value is set. A wide or bytecode caller gets the plain return address.
- R7: On a failed condition, the next PC is the address plus the instruction size, the state is unchanged and the link register is not written.
- R8: Outputs update one clock edge after an accepted request. With `valid_i` low, the next PC, state, read value and link value hold, and `link_we_o` is low.
- R9: While `rst_ni` is low, the next PC is `RESET_PC` (default 0), the state is wide, and the link enable, link value and PC read value are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Branch request accepted this cycle |
| cond_pass_i | input | 1 | Condition result from the evaluator |
| isa_i | input | 2 | Current state: 00 wide, 01 narrow, 11 extended narrow, 10 bytecode |
| kind_i | input | 2 | 00 branch, 01 branch-link, 10 exchange, 11 link-exchange |
| ins32_i | input | 1 | Branch instruction is 4 bytes (used outside the wide state) |
| addr_i | input | AW | Address of the branch instruction |
| offset_i | input | OW | Signed byte offset for immediate branches |
| target_i | input | AW | Register target for exchange branches |
| next_pc_o | output | AW | Next fetch address |
| isa_o | output | 2 | State at the next fetch address |
| pc_read_o | output | AW | Value of a PC operand read by the branch instruction |
| link_we_o | output | 1 | Link register write enable |
| link_val_o | output | AW | Value to write into the link register |

## Verification
The vectors cover immediate branches from each of the four states, to show that the PC read offset and the alignment follow the current state. They include positive, negative and odd offsets, so that offset arithmetic and alignment each become visible. Exchange targets with bit 0 set and clear, issued from both wide and narrow callers, separate the state switch from the link bit-0 tagging. Two-byte and four-byte callers separate the instruction-size term in the return address. Failed conditions on linking and exchanging kinds show that neither the link nor the state is disturbed. Idle cycles and a mid-run reset check that the registers hold their values and return to their reset values.

// File: rtl/bwl_pkg.sv
package bwl_pkg;
  typedef enum logic [1:0] {
    ISA_WIDE     = 2'b00,
    ISA_NARROW   = 2'b01,
    ISA_BYTE     = 2'b10,
    ISA_NARROW_X = 2'b11
  } isa_e;

  typedef enum logic [1:0] {
    BR_PLAIN     = 2'b00,
    BR_LINK      = 2'b01,
    BR_XCHG      = 2'b10,
    BR_LINK_XCHG = 2'b11
  } kind_e;

  function automatic logic kind_links(input kind_e k);
    return k[0];
  endfunction

  function automatic logic kind_from_reg(input kind_e k);
    return k[1];
  endfunction

  // narrow-family states tag return addresses and halfword-align
  function automatic logic isa_is_narrow(input isa_e s);
    return s[0];
  endfunction
endpackage

// File: rtl/bwl_pc_read.sv
module bwl_pc_read
  import bwl_pkg::*;
#(
  parameter int AW = 32
) (
  input  isa_e          isa_i,
  input  logic          ins32_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] pc_read_o,
  output logic [AW-1:0] seq_pc_o
);
  localparam logic [AW-1:0] WideAhead   = AW'(8);
  localparam logic [AW-1:0] NarrowAhead = AW'(4);

  logic [AW-1:0] size;

  always_comb begin
    if (isa_i == ISA_WIDE || ins32_i) size = AW'(4);
    else                              size = AW'(2);
  end

  assign pc_read_o = addr_i + ((isa_i == ISA_WIDE) ? WideAhead : NarrowAhead);
  assign seq_pc_o  = addr_i + size;
endmodule

// File: rtl/bwl_target.sv
module bwl_target
  import bwl_pkg::*;
#(
  parameter int AW = 32,
  parameter int OW = 24
) (
  input  kind_e         kind_i,
  input  isa_e          isa_i,
  input  logic [AW-1:0] pc_read_i,
  input  logic [OW-1:0] offset_i,
  input  logic [AW-1:0] target_i,
  output logic [AW-1:0] tgt_pc_o,
  output isa_e          tgt_isa_o
);
  localparam int ExtW = AW - OW;

  logic [AW-1:0] off_sx;
  logic [AW-1:0] raw_pc;

  generate
    if (ExtW > 0) begin : g_sext
      assign off_sx = {{ExtW{offset_i[OW-1]}}, offset_i};
    end else begin : g_trunc
      assign off_sx = offset_i[AW-1:0];
    end
  endgenerate

  always_comb begin
    if (kind_from_reg(kind_i)) begin
      raw_pc    = target_i;
      tgt_isa_o = target_i[0] ? ISA_NARROW : ISA_WIDE;
    end else begin
      raw_pc    = pc_read_i + off_sx;
      tgt_isa_o = isa_i;
    end
  end

  always_comb begin
    tgt_pc_o = raw_pc;
    unique case (tgt_isa_o)
      ISA_WIDE:               tgt_pc_o[1:0] = 2'b00;
      ISA_NARROW, ISA_NARROW_X: tgt_pc_o[0] = 1'b0;
      default:                ;
    endcase
  end
endmodule

// File: rtl/bwl_link.sv
module bwl_link
  import bwl_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          valid_i,
  input  logic          cond_pass_i,
  input  kind_e         kind_i,
  input  isa_e          isa_i,
  input  logic [AW-1:0] seq_pc_i,
  output logic          link_we_o,
  output logic [AW-1:0] link_val_o
);
  assign link_we_o  = valid_i && cond_pass_i && kind_links(kind_i);
  assign link_val_o = {seq_pc_i[AW-1:1], seq_pc_i[0] | isa_is_narrow(isa_i)};
endmodule

// File: rtl/bwl_unit.sv
module bwl_unit
  import bwl_pkg::*;
#(
  parameter int            AW       = 32,
  parameter int            OW       = 24,
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          cond_pass_i,
  input  logic [1:0]    isa_i,
  input  logic [1:0]    kind_i,
  input  logic          ins32_i,
  input  logic [AW-1:0] addr_i,
  input  logic [OW-1:0] offset_i,
  input  logic [AW-1:0] target_i,
  output logic [AW-1:0] next_pc_o,
  output logic [1:0]    isa_o,
  output logic [AW-1:0] pc_read_o,
  output logic          link_we_o,
  output logic [AW-1:0] link_val_o
);
  isa_e          cur_isa;
  kind_e         kind;
  logic [AW-1:0] pc_read;
  logic [AW-1:0] seq_pc;
  logic [AW-1:0] tgt_pc;
  isa_e          tgt_isa;
  logic          link_we;
  logic [AW-1:0] link_val;
  logic [AW-1:0] nxt_pc;
  isa_e          nxt_isa;

  assign cur_isa = isa_e'(isa_i);
  assign kind    = kind_e'(kind_i);

  bwl_pc_read #(.AW(AW)) u_read (
    .isa_i    (cur_isa),
    .ins32_i  (ins32_i),
    .addr_i   (addr_i),
    .pc_read_o(pc_read),
    .seq_pc_o (seq_pc)
  );

  bwl_target #(.AW(AW), .OW(OW)) u_tgt (
    .kind_i   (kind),
    .isa_i    (cur_isa),
    .pc_read_i(pc_read),
    .offset_i (offset_i),
    .target_i (target_i),
    .tgt_pc_o (tgt_pc),
    .tgt_isa_o(tgt_isa)
  );

  bwl_link #(.AW(AW)) u_link (
    .valid_i    (valid_i),
    .cond_pass_i(cond_pass_i),
    .kind_i     (kind),
    .isa_i      (cur_isa),
    .seq_pc_i   (seq_pc),
    .link_we_o  (link_we),
    .link_val_o (link_val)
  );

  // failed condition falls through in the current state
  assign nxt_pc  = cond_pass_i ? tgt_pc  : seq_pc;
  assign nxt_isa = cond_pass_i ? tgt_isa : cur_isa;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      next_pc_o  <= RESET_PC;
      isa_o      <= ISA_WIDE;
      pc_read_o  <= '0;
      link_we_o  <= 1'b0;
      link_val_o <= '0;
    end else begin
      link_we_o <= link_we;
      if (valid_i) begin
        next_pc_o  <= nxt_pc;
        isa_o      <= nxt_isa;
        pc_read_o  <= pc_read;
        link_val_o <= link_val;
      end
    end
  end

  assert_wide_align_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (isa_o == ISA_WIDE) |-> (next_pc_o[1:0] == 2'b00));

  assert_narrow_align_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    isa_o[0] |-> !next_pc_o[0]);

  assert_pc_read_wide_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_i && isa_i == ISA_WIDE) |-> (pc_read_o == $past(addr_i) + AW'(8)));

  assert_link_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_we_o |-> $past(valid_i && cond_pass_i && kind_i[0]));

  assert_link_tag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_i && isa_i[0]) |-> link_val_o[0]);

  assert_fail_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_i && !cond_pass_i) |-> (!link_we_o && isa_o == $past(isa_i)));

  assert_idle_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!valid_i) |-> ($stable(next_pc_o) && $stable(isa_o) && !link_we_o));
endmodule

// File: tb/bwl_unit_test.sv
module bwl_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int OW = 24;
  localparam int NV = 15;

  typedef struct packed {
    logic [7:0]    req;
    logic [1:0]    isa;
    logic [1:0]    kind;
    logic          ins32;
    logic          pass;
    logic [AW-1:0] addr;
    logic [OW-1:0] off;
    logic [AW-1:0] tgt;
    logic [AW-1:0] e_pc;
    logic [1:0]    e_isa;
    logic          e_we;
    logic [AW-1:0] e_link;
    logic [AW-1:0] e_read;
  } vec_t;

  // kinds: 00 B, 01 BL, 10 BX, 11 BLX; states: 00 wide, 01 narrow, 11 ext, 10 bytecode
  localparam vec_t VEC [NV] = '{
    '{8'd2, 2'b00, 2'b00, 1'b0, 1'b1, 32'h1000, 24'h000020, 32'h0, 32'h1028, 2'b00, 1'b0, 32'h1004, 32'h1008}, // R2 R1
    '{8'd2, 2'b00, 2'b01, 1'b0, 1'b1, 32'h2000, 24'hFFFFF0, 32'h0, 32'h1FF8, 2'b00, 1'b1, 32'h2004, 32'h2008}, // R2 R5 neg
    '{8'd6, 2'b01, 2'b01, 1'b1, 1'b1, 32'h3002, 24'h000100, 32'h0, 32'h3106, 2'b01, 1'b1, 32'h3007, 32'h3006}, // R6 R1
    '{8'd4, 2'b01, 2'b00, 1'b0, 1'b1, 32'h4000, 24'h000007, 32'h0, 32'h400A, 2'b01, 1'b0, 32'h4003, 32'h4004}, // R4
    '{8'd3, 2'b01, 2'b10, 1'b0, 1'b1, 32'h5000, 24'h0, 32'h80000101, 32'h80000100, 2'b01, 1'b0, 32'h5003, 32'h5004}, // R3
    '{8'd3, 2'b01, 2'b10, 1'b0, 1'b1, 32'h5100, 24'h0, 32'h6002, 32'h6000, 2'b00, 1'b0, 32'h5103, 32'h5104}, // R3 R4
    '{8'd3, 2'b00, 2'b11, 1'b0, 1'b1, 32'h9000, 24'h0, 32'h7005, 32'h7004, 2'b01, 1'b1, 32'h9004, 32'h9008}, // R3 R5
    '{8'd5, 2'b01, 2'b11, 1'b1, 1'b1, 32'hB000, 24'h0, 32'hA00C, 32'hA00C, 2'b00, 1'b1, 32'hB005, 32'hB004}, // R5 R6
    '{8'd7, 2'b00, 2'b01, 1'b0, 1'b0, 32'hC000, 24'h000040, 32'h0, 32'hC004, 2'b00, 1'b0, 32'hC004, 32'hC008}, // R7
    '{8'd7, 2'b01, 2'b11, 1'b0, 1'b0, 32'hD002, 24'h0, 32'h1, 32'hD004, 2'b01, 1'b0, 32'hD005, 32'hD006}, // R7
    '{8'd4, 2'b11, 2'b00, 1'b0, 1'b1, 32'hE000, 24'h000011, 32'h0, 32'hE014, 2'b11, 1'b0, 32'hE003, 32'hE004}, // R4 ext
    '{8'd4, 2'b10, 2'b01, 1'b0, 1'b1, 32'hF000, 24'h000003, 32'h0, 32'hF007, 2'b10, 1'b1, 32'hF002, 32'hF004}, // R4 R6 bytecode
    '{8'd4, 2'b00, 2'b00, 1'b0, 1'b1, 32'h0200, 24'h000006, 32'h0, 32'h020C, 2'b00, 1'b0, 32'h0204, 32'h0208}, // R4 wide
    '{8'd3, 2'b00, 2'b10, 1'b0, 1'b1, 32'h0010, 24'h0, 32'h4443, 32'h4442, 2'b01, 1'b0, 32'h0014, 32'h0018}, // R3
    '{8'd3, 2'b11, 2'b11, 1'b0, 1'b1, 32'h0100, 24'h0, 32'h0020, 32'h0020, 2'b00, 1'b1, 32'h0103, 32'h0104}  // R3 R6
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          valid_i = 1'b0;
  logic          cond_pass_i = 1'b0;
  logic [1:0]    isa_i = '0;
  logic [1:0]    kind_i = '0;
  logic          ins32_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [OW-1:0] offset_i = '0;
  logic [AW-1:0] target_i = '0;
  logic [AW-1:0] next_pc_o;
  logic [1:0]    isa_o;
  logic [AW-1:0] pc_read_o;
  logic          link_we_o;
  logic [AW-1:0] link_val_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  bwl_unit #(.AW(AW), .OW(OW)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .cond_pass_i(cond_pass_i),
    .isa_i(isa_i), .kind_i(kind_i), .ins32_i(ins32_i), .addr_i(addr_i),
    .offset_i(offset_i), .target_i(target_i), .next_pc_o(next_pc_o), .isa_o(isa_o),
    .pc_read_o(pc_read_o), .link_we_o(link_we_o), .link_val_o(link_val_o)
  );

  task automatic chk(input string req, input string what, input logic [AW-1:0] act,
                     input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v, input logic vld);
    valid_i     = vld;
    isa_i       = v.isa;
    kind_i      = v.kind;
    ins32_i     = v.ins32;
    cond_pass_i = v.pass;
    addr_i      = v.addr;
    offset_i    = v.off;
    target_i    = v.tgt;
  endtask

  task automatic chk_vec(input vec_t v);
    string r;
    r = $sformatf("R%0d", v.req);
    chk(r, "next_pc", next_pc_o, v.e_pc);
    chk(r, "isa", AW'(isa_o), AW'(v.e_isa));
    chk(r, "link_we", AW'(link_we_o), AW'(v.e_we));
    chk(r, "link_val", link_val_o, v.e_link);
    chk(r, "pc_read", pc_read_o, v.e_read);
  endtask

  task automatic chk_reset();
    chk("R9", "next_pc", next_pc_o, '0);
    chk("R9", "isa", AW'(isa_o), '0);
    chk("R9", "link_we", AW'(link_we_o), '0);
    chk("R9", "link_val", link_val_o, '0);
    chk("R9", "pc_read", pc_read_o, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk_reset();
    rst_ni = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      drive(VEC[i], 1'b1);
      @(negedge clk_i);
      chk_vec(VEC[i]);
    end
    // R8: idle cycle with different inputs holds results and drops link enable
    drive(VEC[0], 1'b0);
    @(negedge clk_i);
    chk("R8", "idle next_pc", next_pc_o, 32'h0020);
    chk("R8", "idle isa", AW'(isa_o), AW'(2'b00));
    chk("R8", "idle link_we", AW'(link_we_o), '0);
    chk("R8", "idle link_val", link_val_o, 32'h0103);
    chk("R8", "idle pc_read", pc_read_o, 32'h0104);
    // R8: one-edge latency, outputs unchanged before the edge
    drive(VEC[6], 1'b1);
    #1;
    chk("R8", "pre-edge next_pc", next_pc_o, 32'h0020);
    @(negedge clk_i);
    chk_vec(VEC[6]);
    // R9: asynchronous reset mid-run
    valid_i = 1'b0;
    #1 rst_ni = 1'b0;
    #1;
    chk_reset();
    @(negedge clk_i);
    rst_ni = 1'b1;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (2000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule